// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register front end of a 64-channel DMA controller. A simple 32-bit bus with per-byte enables reads and writes a set of per-channel bitmaps: request enables, error-interrupt enables, interrupt-pending flags and error-pending flags. Each bitmap is held as two words. The high word covers channels 63 down to 32, with bit k standing for channel 32+k. The low word covers channels 31 down to 0. A control word selects the clock gating and arbitration options, and a read-only status word records the first error that the channel engines report.

Besides the word-wide access, eight byte-wide command registers each act on a single channel whose number is written into the byte. They set or clear the enables, clear pending flags, start a channel or clear its done state. Interrupt and error flags are raised by event inputs from the channel engines. The block drives per-channel start and clear-done pulses, the request-enable vector, the control options and one combined interrupt line. Reads are combinational in the request cycle. Writes take effect at the clock edge that samples them.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset every readable word is zero, every output vector is zero and irq_o is low.
- R2: Word address (addr_i) map: 0 control, 1 error status, 2/3 request enable high/low, 4/5 error-interrupt enable high/low, 6/7 command bytes, 8/9 interrupt pending high/low, 10/11 error pending high/low; others read zero. rdata_o is zero unless req_i is high and we_i low. Control bits 31 (clock gating), 3 (round-robin group) and 2 (round-robin channel) are writable under their byte enables, and all other control bits read zero.
- R3: The request-enable and error-interrupt-enable words are read/write, and each byte lane is written only when its byte enable is set. req_en_o presents the request-enable bitmap as {high, low}.
- R4: A command byte acts on the channel given by its bits 5:0, and bits 7:6 are ignored. Lane k of word 6 (bits 8k+7:8k) is, for k = 0..3: set request enable, clear request enable, set error-interrupt enable, clear error-interrupt enable. Lanes 0..3 of word 7 are: clear interrupt, clear error, start, clear done. A lane acts only when its byte enable is set. When set and clear of the same enable name the same channel in one write, set wins.
- R5: Command words read as zero.
- R6: An event input bit sets the matching pending bit. Writing ones to a pending word clears those bits (write-one-to-clear), and the clear-interrupt and clear-error commands clear one channel's bit.
- R7: An event that arrives in the same cycle as a clear of the same pending bit leaves the bit set.
- R8: With the valid bit clear, err_rep_i captures the status word as bit 31 valid, bits 15:14 = err_kind_i[9:8], bits 13:8 = err_ch_i, bits 7:0 = err_kind_i[7:0], all other bits zero. While valid is set, the word holds against further reports.
- R9: Clearing the error-pending bit of the recorded channel zeroes the status word, unless an error event for that channel arrives in the same cycle.
- R10: irq_o is high when any interrupt-pending bit is set, or when any error-pending bit is set and its error-interrupt enable is also set.
- R11: A start command drives start_o high for the named channel for exactly the one cycle after the write. A clear-done command does the same on done_clr_o.
- R12: Writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 6 | Word address |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_evt_i | input | 64 | Per-channel interrupt events |
| err_evt_i | input | 64 | Per-channel error events |
| err_rep_i | input | 1 | Error report strobe for status capture |
| err_ch_i | input | 6 | Channel of the reported error |
| err_kind_i | input | 10 | Error kind flags of the report |
| req_en_o | output | 64 | Request-enable bitmap |
| clk_gate_o | output | 1 | Clock gating enable |
| rr_group_o | output | 1 | Round-robin group arbitration |
| rr_chan_o | output | 1 | Round-robin channel arbitration |
| start_o | output | 64 | Per-channel start pulses |
| done_clr_o | output | 64 | Per-channel clear-done pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
Read data is due in the request cycle itself, so the bench checks rdata_o shortly after it drives a read and before the next clock edge. Every register effect, whether from a bus write, an event or an error report, shows up one clock edge after it is sampled. Those effects cover the bitmaps, the status word, req_en_o, the control outputs, the start and clear-done pulses and irq_o. The bench drives stimulus on falling edges, updates its reference model on the rising edge and compares every registered output on the next falling edge. The one-cycle width of the pulses and the hold of the status word are therefore checked on every cycle.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int NUM_CH   = 2 * DATA_W;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int ADDR_W   = 6;
  localparam int CMD_NUM  = 2 * BE_W;
  localparam int KIND_W   = 10;

  localparam logic [ADDR_W-1:0] IDX_CTRL   = 6'd0;
  localparam logic [ADDR_W-1:0] IDX_STAT   = 6'd1;
  localparam logic [ADDR_W-1:0] IDX_REQ_HI = 6'd2;
  localparam logic [ADDR_W-1:0] IDX_REQ_LO = 6'd3;
  localparam logic [ADDR_W-1:0] IDX_EEI_HI = 6'd4;
  localparam logic [ADDR_W-1:0] IDX_EEI_LO = 6'd5;
  localparam logic [ADDR_W-1:0] IDX_CMD_A  = 6'd6;
  localparam logic [ADDR_W-1:0] IDX_CMD_B  = 6'd7;
  localparam logic [ADDR_W-1:0] IDX_INT_HI = 6'd8;
  localparam logic [ADDR_W-1:0] IDX_INT_LO = 6'd9;
  localparam logic [ADDR_W-1:0] IDX_ERR_HI = 6'd10;
  localparam logic [ADDR_W-1:0] IDX_ERR_LO = 6'd11;

  // command lane order is part of the map
  typedef enum int {
    CMD_SET_REQ   = 0,
    CMD_CLR_REQ   = 1,
    CMD_SET_EEI   = 2,
    CMD_CLR_EEI   = 3,
    CMD_CLR_INT   = 4,
    CMD_CLR_ERR   = 5,
    CMD_SET_START = 6,
    CMD_CLR_DONE  = 7
  } cmd_e;

  localparam int CTRL_CLKGATE = 31;
  localparam int CTRL_RR_GRP  = 3;
  localparam int CTRL_RR_CH   = 2;
endpackage

// File: rtl/csr_cmd_decode.sv
module csr_cmd_decode
  import dma_csr_pkg::*;
(
  input  logic                              wr_a_i,
  input  logic                              wr_b_i,
  input  logic [BE_W-1:0]                   be_i,
  input  logic [BE_W-1:0][CH_W-1:0]         lane_ch_i,
  output logic [CMD_NUM-1:0][NUM_CH-1:0]    hit_o
);
  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < CMD_NUM; c++) begin : g_cmd
    localparam int LANE = c % BE_W;
    logic act;
    if (c < BE_W) begin : g_a
      assign act = wr_a_i & be_i[LANE];
    end else begin : g_b
      assign act = wr_b_i & be_i[LANE];
    end
    assign hit_o[c] = act ? (ONE << lane_ch_i[LANE]) : '0;
  end
endmodule

// File: rtl/csr_bitmap.sv
module csr_bitmap
  import dma_csr_pkg::*;
#(
  parameter bit W1C = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] q_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic [NUM_CH-1:0] wmask, wdat2, d;

  assign wdat2 = {wdata_i, wdata_i};

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign wmask[l*8 +: 8]          = {8{wr_lo_i & be_i[l]}};
    assign wmask[DATA_W + l*8 +: 8] = {8{wr_hi_i & be_i[l]}};
  end

  if (W1C) begin : g_w1c
    assign clr_o = (wmask & wdat2) | clr_i;
    assign d     = (q_o & ~clr_o) | set_i;
  end else begin : g_rw
    assign clr_o = clr_i;
    assign d     = (((q_o & ~wmask) | (wdat2 & wmask)) & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/csr_err_capture.sv
module csr_err_capture
  import dma_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rep_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] evt_i,
  output logic [DATA_W-1:0] stat_o
);
  logic              valid_q;
  logic [CH_W-1:0]   ch_q;
  logic [KIND_W-1:0] kind_q;
  logic              drop;

  assign drop = valid_q & clr_i[ch_q] & ~evt_i[ch_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
      kind_q  <= '0;
    end else if (!valid_q && rep_i) begin
      valid_q <= 1'b1;
      ch_q    <= ch_i;
      kind_q  <= kind_i;
    end else if (drop) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
      kind_q  <= '0;
    end
  end

  assign stat_o = {valid_q, 15'd0, kind_q[9:8], ch_q, kind_q[7:0]};
endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] irq_evt_i,
  input  logic [NUM_CH-1:0] err_evt_i,
  input  logic              err_rep_i,
  input  logic [CH_W-1:0]   err_ch_i,
  input  logic [KIND_W-1:0] err_kind_i,
  output logic [NUM_CH-1:0] req_en_o,
  output logic              clk_gate_o,
  output logic              rr_group_o,
  output logic              rr_chan_o,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_clr_o,
  output logic              irq_o
);
  logic wr;
  logic [CMD_NUM-1:0][NUM_CH-1:0] hit;
  logic [BE_W-1:0][CH_W-1:0] lane_ch;
  logic [NUM_CH-1:0] eei_q, int_q, err_q, err_clr;
  logic [NUM_CH-1:0] req_clr_unused, eei_clr_unused, int_clr_unused;
  logic [DATA_W-1:0] err_stat;
  logic [NUM_CH-1:0] start_q, done_q;
  logic clkg_q, rrg_q, rrc_q;

  assign wr = req_i & we_i;

  for (genvar l = 0; l < BE_W; l++) begin : g_lane_ch
    assign lane_ch[l] = wdata_i[l*8 +: CH_W];
  end

  csr_cmd_decode u_cmd (
    .wr_a_i   (wr && addr_i == IDX_CMD_A),
    .wr_b_i   (wr && addr_i == IDX_CMD_B),
    .be_i     (be_i),
    .lane_ch_i(lane_ch),
    .hit_o    (hit)
  );

  csr_bitmap #(.W1C(1'b0)) u_req (
    .clk_i, .rst_ni,
    .wr_hi_i(wr && addr_i == IDX_REQ_HI),
    .wr_lo_i(wr && addr_i == IDX_REQ_LO),
    .be_i, .wdata_i,
    .set_i(hit[CMD_SET_REQ]), .clr_i(hit[CMD_CLR_REQ]),
    .q_o(req_en_o), .clr_o(req_clr_unused)
  );

  csr_bitmap #(.W1C(1'b0)) u_eei (
    .clk_i, .rst_ni,
    .wr_hi_i(wr && addr_i == IDX_EEI_HI),
    .wr_lo_i(wr && addr_i == IDX_EEI_LO),
    .be_i, .wdata_i,
    .set_i(hit[CMD_SET_EEI]), .clr_i(hit[CMD_CLR_EEI]),
    .q_o(eei_q), .clr_o(eei_clr_unused)
  );

  csr_bitmap #(.W1C(1'b1)) u_int (
    .clk_i, .rst_ni,
    .wr_hi_i(wr && addr_i == IDX_INT_HI),
    .wr_lo_i(wr && addr_i == IDX_INT_LO),
    .be_i, .wdata_i,
    .set_i(irq_evt_i), .clr_i(hit[CMD_CLR_INT]),
    .q_o(int_q), .clr_o(int_clr_unused)
  );

  csr_bitmap #(.W1C(1'b1)) u_err (
    .clk_i, .rst_ni,
    .wr_hi_i(wr && addr_i == IDX_ERR_HI),
    .wr_lo_i(wr && addr_i == IDX_ERR_LO),
    .be_i, .wdata_i,
    .set_i(err_evt_i), .clr_i(hit[CMD_CLR_ERR]),
    .q_o(err_q), .clr_o(err_clr)
  );

  csr_err_capture u_cap (
    .clk_i, .rst_ni,
    .rep_i (err_rep_i),
    .ch_i  (err_ch_i),
    .kind_i(err_kind_i),
    .clr_i (err_clr),
    .evt_i (err_evt_i),
    .stat_o(err_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clkg_q  <= 1'b0;
      rrg_q   <= 1'b0;
      rrc_q   <= 1'b0;
      start_q <= '0;
      done_q  <= '0;
    end else begin
      if (wr && addr_i == IDX_CTRL) begin
        if (be_i[CTRL_CLKGATE/8]) clkg_q <= wdata_i[CTRL_CLKGATE];
        if (be_i[CTRL_RR_GRP/8])  rrg_q  <= wdata_i[CTRL_RR_GRP];
        if (be_i[CTRL_RR_CH/8])   rrc_q  <= wdata_i[CTRL_RR_CH];
      end
      start_q <= hit[CMD_SET_START];
      done_q  <= hit[CMD_CLR_DONE];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        IDX_CTRL: begin
          rdata_o[CTRL_CLKGATE] = clkg_q;
          rdata_o[CTRL_RR_GRP]  = rrg_q;
          rdata_o[CTRL_RR_CH]   = rrc_q;
        end
        IDX_STAT:   rdata_o = err_stat;
        IDX_REQ_HI: rdata_o = req_en_o[NUM_CH-1:DATA_W];
        IDX_REQ_LO: rdata_o = req_en_o[DATA_W-1:0];
        IDX_EEI_HI: rdata_o = eei_q[NUM_CH-1:DATA_W];
        IDX_EEI_LO: rdata_o = eei_q[DATA_W-1:0];
        IDX_INT_HI: rdata_o = int_q[NUM_CH-1:DATA_W];
        IDX_INT_LO: rdata_o = int_q[DATA_W-1:0];
        IDX_ERR_HI: rdata_o = err_q[NUM_CH-1:DATA_W];
        IDX_ERR_LO: rdata_o = err_q[DATA_W-1:0];
        default:    rdata_o = '0;
      endcase
    end
  end

  assign clk_gate_o = clkg_q;
  assign rr_group_o = rrg_q;
  assign rr_chan_o  = rrc_q;
  assign start_o    = start_q;
  assign done_clr_o = done_q;
  assign irq_o      = (|int_q) | (|(err_q & eei_q));
endmodule

// File: rtl/dma_csr_regs_chk.sv
module dma_csr_regs_chk
  import dma_csr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              start_lane_i,
  input logic [NUM_CH-1:0] irq_evt_i,
  input logic              err_rep_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] start_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] err_stat
);
  p_cmd_rd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == IDX_CMD_A || addr_i == IDX_CMD_B)) |-> rdata_o == '0);

  p_wr_no_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> rdata_o == '0);

  p_start_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o) |-> $past(req_i && we_i && addr_i == IDX_CMD_B && start_lane_i));

  p_irq_evt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_evt_i) |=> irq_o);

  p_stat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_stat[DATA_W-1] && $past(err_stat[DATA_W-1])) |-> err_stat == $past(err_stat));

  p_stat_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_stat[DATA_W-1]) |-> $past(err_rep_i));
endmodule

bind dma_csr_regs dma_csr_regs_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .start_lane_i(be_i[dma_csr_pkg::CMD_SET_START % dma_csr_pkg::BE_W]),
  .irq_evt_i   (irq_evt_i),
  .err_rep_i   (err_rep_i),
  .rdata_o     (rdata_o),
  .start_o     (start_o),
  .irq_o       (irq_o),
  .err_stat    (err_stat)
);

// File: tb/dma_csr_regs_tb_top.sv
module dma_csr_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] irq_evt_i = '0, err_evt_i = '0;
  logic        err_rep_i = 1'b0;
  logic [5:0]  err_ch_i = '0;
  logic [9:0]  err_kind_i = '0;
  logic [63:0] req_en_o, start_o, done_clr_o;
  logic        clk_gate_o, rr_group_o, rr_chan_o, irq_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_csr_regs dut_i (.*);

  // reference model state
  bit        m_clkg, m_rrg, m_rrc;
  bit [63:0] m_req, m_eei, m_int, m_err, m_start, m_done;
  bit        m_valid;
  bit [5:0]  m_ch;
  bit [9:0]  m_kind;

  function automatic bit [31:0] bytemask(input bit [3:0] be);
    bit [31:0] m = 0;
    for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic bit [31:0] m_stat();
    bit [31:0] s = 0;
    if (m_valid) begin
      s[31] = 1; s[15:14] = m_kind[9:8]; s[13:8] = m_ch; s[7:0] = m_kind[7:0];
    end
    return s;
  endfunction

  function automatic bit [31:0] mread(input int a);
    case (a)
      0:  return {m_clkg, 27'd0, m_rrg, m_rrc, 2'd0};
      1:  return m_stat();
      2:  return m_req[63:32];
      3:  return m_req[31:0];
      4:  return m_eei[63:32];
      5:  return m_eei[31:0];
      8:  return m_int[63:32];
      9:  return m_int[31:0];
      10: return m_err[63:32];
      11: return m_err[31:0];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_clkg = 0; m_rrg = 0; m_rrc = 0;
      m_req = 0; m_eei = 0; m_int = 0; m_err = 0; m_start = 0; m_done = 0;
      m_valid = 0; m_ch = 0; m_kind = 0;
    end else begin
      bit [63:0] cmd [8];
      bit [63:0] wm, wd, iclr, eclr;
      bit        wr;
      wr = req_i && we_i;
      wd = {wdata_i, wdata_i};
      for (int c = 0; c < 8; c++) begin
        cmd[c] = 0;
        if (wr && addr_i == 6 + c / 4 && be_i[c % 4])
          cmd[c][wdata_i[(c % 4) * 8 +: 6]] = 1'b1;
      end
      if (wr && addr_i == 0) begin
        if (be_i[3]) m_clkg = wdata_i[31];
        if (be_i[0]) begin m_rrg = wdata_i[3]; m_rrc = wdata_i[2]; end
      end
      wm = 0;
      if (wr && addr_i == 3) wm[31:0]  = bytemask(be_i);
      if (wr && addr_i == 2) wm[63:32] = bytemask(be_i);
      m_req = (((m_req & ~wm) | (wd & wm)) & ~cmd[1]) | cmd[0];
      wm = 0;
      if (wr && addr_i == 5) wm[31:0]  = bytemask(be_i);
      if (wr && addr_i == 4) wm[63:32] = bytemask(be_i);
      m_eei = (((m_eei & ~wm) | (wd & wm)) & ~cmd[3]) | cmd[2];
      iclr = cmd[4];
      if (wr && addr_i == 9) iclr[31:0]  = iclr[31:0]  | (wdata_i & bytemask(be_i));
      if (wr && addr_i == 8) iclr[63:32] = iclr[63:32] | (wdata_i & bytemask(be_i));
      m_int = (m_int & ~iclr) | irq_evt_i;
      eclr = cmd[5];
      if (wr && addr_i == 11) eclr[31:0]  = eclr[31:0]  | (wdata_i & bytemask(be_i));
      if (wr && addr_i == 10) eclr[63:32] = eclr[63:32] | (wdata_i & bytemask(be_i));
      m_err = (m_err & ~eclr) | err_evt_i;
      if (!m_valid && err_rep_i) begin
        m_valid = 1; m_ch = err_ch_i; m_kind = err_kind_i;
      end else if (m_valid && eclr[m_ch] && !err_evt_i[m_ch]) begin
        m_valid = 0; m_ch = 0; m_kind = 0;
      end
      m_start = cmd[6];
      m_done  = cmd[7];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R3 req_en_o", req_en_o, m_req);
      chk("R2 ctrl outputs", {61'd0, clk_gate_o, rr_group_o, rr_chan_o}, {61'd0, m_clkg, m_rrg, m_rrc});
      chk("R11 start_o", start_o, m_start);
      chk("R11 done_clr_o", done_clr_o, m_done);
      chk("R10 irq_o", irq_o, (m_int != 0) || ((m_err & m_eei) != 0));
    end
  end

  task automatic cyc(input bit rq, input bit we, input int a, input bit [3:0] be,
                     input bit [31:0] wd, input bit [63:0] ie, input bit [63:0] ee,
                     input bit rep, input bit [5:0] ch, input bit [9:0] kd, input string tag);
    @(negedge clk_i);
    req_i = rq; we_i = we; addr_i = a[5:0]; be_i = be; wdata_i = wd;
    irq_evt_i = ie; err_evt_i = ee; err_rep_i = rep; err_ch_i = ch; err_kind_i = kd;
    #1;
    if (rq && !we) chk(tag, rdata_o, mread(a));
  endtask

  task automatic wr(input int a, input bit [3:0] be, input bit [31:0] wd);
    cyc(1, 1, a, be, wd, 0, 0, 0, 0, 0, "");
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1, 0, a, 4'hF, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, "R1 reset read");
      chk("R1 reset read literal", rdata_o, 0);
    end
    chk("R1 irq_o after reset", irq_o, 0);
    chk("R1 start_o after reset", start_o, 0);

    // R2 control word and byte enables
    wr(0, 4'hF, 32'hFFFF_FFFF);
    rd(0, "R2 ctrl");
    chk("R2 ctrl literal", rdata_o, 32'h8000_000C);
    wr(0, 4'h1, 32'h0);
    rd(0, "R2 ctrl byte enable");
    chk("R2 ctrl be literal", rdata_o, 32'h8000_0000);

    // R3 enable words with byte masks
    wr(3, 4'h5, 32'hA5A5_A5A5);
    wr(2, 4'hF, 32'h1234_5678);
    rd(3, "R3 req lo");
    chk("R3 req lo literal", rdata_o, 32'h00A5_00A5);

    // R4 commands: set ch40, clear ch0 with bits 7:6 set
    wr(6, 4'h3, {16'h0, 8'hC0, 8'd40});
    rd(2, "R4 req hi");
    chk("R4 set ch40", rdata_o, 32'h1234_5778);
    rd(3, "R4 req lo");
    chk("R4 clr ch0 ignoring bits 7:6", rdata_o, 32'h00A5_00A4);
    // R4 set and clear of ch9 in one write: set wins
    wr(6, 4'h3, {16'h0, 8'd9, 8'd9});
    rd(3, "R4 set wins");
    chk("R4 set wins literal", rdata_o, 32'h00A5_02A4);
    // R4 disabled lane has no effect
    wr(6, 4'h2, {16'h0, 8'd10, 8'd12});
    rd(3, "R4 lane enable");
    chk("R4 masked lane literal", rdata_o, 32'h00A5_02A4);
    wr(6, 4'h4, {8'h0, 8'd3, 16'h0});
    wr(6, 4'h4, {8'h0, 8'd40, 16'h0});
    rd(4, "R4 eei hi");
    chk("R4 eei ch40", rdata_o, 32'h0000_0100);

    // R5 command reads
    rd(6, "R5 cmd a read");
    chk("R5 cmd a zero", rdata_o, 0);
    rd(7, "R5 cmd b read");
    chk("R5 cmd b zero", rdata_o, 0);

    // R6 interrupt events and clears
    cyc(0, 0, 0, 0, 0, (64'd1 << 33) | 64'd2, 0, 0, 0, 0, "");
    rd(9, "R6 int lo");
    chk("R6 int lo literal", rdata_o, 32'h2);
    rd(8, "R6 int hi");
    chk("R6 int hi literal", rdata_o, 32'h2);
    chk("R10 irq on int", irq_o, 1);
    wr(9, 4'hF, 32'h2);
    wr(7, 4'h1, 32'd33);
    rd(8, "R6 cmd clear");
    chk("R6 int hi cleared", rdata_o, 0);
    rd(9, "R6 w1c clear");
    chk("R6 int lo cleared", rdata_o, 0);
    chk("R10 irq low", irq_o, 0);

    // R7 event beats clear
    cyc(1, 1, 9, 4'hF, 32'h4, 64'h4, 0, 0, 0, 0, "");
    rd(9, "R7 event wins");
    chk("R7 literal", rdata_o, 32'h4);
    wr(9, 4'hF, 32'h4);
    rd(9, "R7 cleared after");
    chk("R7 cleared literal", rdata_o, 0);

    // R10 error without enable, then with enable; R8 capture
    cyc(0, 0, 0, 0, 0, 0, 64'h20, 0, 0, 0, "");
    idle();
    chk("R10 masked error", irq_o, 0);
    cyc(0, 0, 0, 0, 0, 0, 64'h8, 1, 6'd3, 10'b10_0000_0001, "");
    idle();
    chk("R10 enabled error", irq_o, 1);
    rd(1, "R8 status");
    chk("R8 capture literal", rdata_o, 32'h8000_8301);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 6'd5, 10'h3FF, "");
    rd(1, "R8 hold");
    chk("R8 hold literal", rdata_o, 32'h8000_8301);
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd(1, "R12 write ignored");
    chk("R12 literal", rdata_o, 32'h8000_8301);

    // R9 valid clearing
    wr(7, 4'h2, {16'h0, 8'd5, 8'h0});
    rd(1, "R9 other channel clear");
    chk("R9 other ch literal", rdata_o, 32'h8000_8301);
    cyc(1, 1, 11, 4'hF, 32'h8, 0, 64'h8, 0, 0, 0, "");
    rd(1, "R9 clear with event");
    chk("R9 clear+event literal", rdata_o, 32'h8000_8301);
    wr(11, 4'hF, 32'h8);
    rd(1, "R9 cleared");
    chk("R9 cleared literal", rdata_o, 0);
    rd(11, "R9 err lo");
    chk("R9 err lo literal", rdata_o, 0);

    // R3 clear eei via lane 3
    wr(6, 4'h8, {8'd3, 24'h0});
    rd(5, "R3 eei lo");
    chk("R3 eei lo literal", rdata_o, 0);

    // R11 pulses
    wr(7, 4'hC, {8'd50, 8'd7, 16'h0});
    idle();
    chk("R11 start pulse", start_o, 64'd1 << 7);
    chk("R11 done pulse", done_clr_o, 64'd1 << 50);
    idle();
    chk("R11 start ends", start_o, 0);
    chk("R11 done ends", done_clr_o, 0);

    // mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      bit [63:0] ie, ee;
      ie = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      ee = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 13),
          4'($urandom), $urandom, ie, ee, $urandom_range(0, 7) == 0,
          6'($urandom), 10'($urandom), "R2 mixed read");
    end
    idle();
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule